// File: doc/BRIEF.md
# Speculative Register State Tracker

This block sits beside the rename stage of an out-of-order core and records, for every logical register, whether its newest value came from an instruction decoded after a branch that is still unresolved. It also records which branch that was. A global branch counter hands each decoded branch an index. Each producer that is decoded stamps its destination register with the current index and marks that register as speculative. A retiring producer that is still the newest definition of its register clears the mark.

When a branch is found to be mispredicted, the core presents that branch's index. In the same cycle the block returns a mask with one bit per logical register. The mask selects exactly the registers that were written on the wrong path, so recovery can repair those registers and leave the rest alone.

Indices wrap. Each index carries a color bit above the counter value, which keeps the order correct across a wrap. The block has no storage for map tables, physical registers or the reorder buffer.

Top module: `spec_reg_tracker`

## Requirements
- R1: After reset every register is non-speculative and the branch counter is zero. The first branch decoded therefore receives index 1.
- R2: `br_idx_o` always shows the current counter plus one, which is the index the next decoded branch receives. When `br_dec_i` is high the counter takes that value at the clock edge. When `br_dec_i` is low the counter holds.
- R3: A producer decode (`prod_dec_i`) writes the current counter value into the entry of register `prod_dst_i` and sets that entry's speculative flag.
- R4: A retire (`ret_i`) with `ret_latest_i` high clears the speculative flag of `ret_dst_i`. A retire with `ret_latest_i` low changes nothing.
- R5: If a producer decode and a clearing retire name the same register in the same cycle, the decode wins. The register ends speculative and carries the decode's index.
- R6: If a branch decode and a producer decode happen in the same cycle, the producer is stamped with the newly incremented index, which equals `br_idx_o` in that cycle.
- R7: An index is IDX_W = log2(MAX_BR)+1 bits wide. The low log2(MAX_BR) bits hold the counter value and the top bit is the color. Counting from value MAX_BR-1 wraps the value to 0 and flips the color.
- R8: While `misp_i` is high, bit r of `spec_mask_o` is 1 exactly when register r is speculative and its stored index is greater than or equal to `misp_idx_i` in circular order. An index A is greater than B when the colors match and A's value is larger, or when the colors differ and A's value is smaller. The mask is combinational, valid in the same cycle as the request.
- R9: While `misp_i` is low, `spec_mask_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_dec_i | input | 1 | A branch is decoded this cycle |
| br_idx_o | output | IDX_W | Index given to a branch decoded this cycle |
| prod_dec_i | input | 1 | A register producer is decoded this cycle |
| prod_dst_i | input | RW | Destination register of the decoded producer |
| ret_i | input | 1 | A producer retires this cycle |
| ret_dst_i | input | RW | Destination register of the retiring producer |
| ret_latest_i | input | 1 | The retiring producer is still the newest definition of its register |
| misp_i | input | 1 | Misprediction query valid |
| misp_idx_i | input | IDX_W | Index of the mispredicted branch |
| spec_mask_o | output | NUM_REGS | Registers written on the wrong path |

## Verification
The bench runs a small configuration: 8 registers and 4 in-flight branches, giving 3-bit indices. It sweeps every query index against register tables built by a long pseudo-random stream. The streams run the counter through many wraps, so a comparator that ignores the color bit or inverts its sense shows up as wrong mask bits right after a wrap.

Directed sequences target the following same-cycle collisions and what a faulty design does in each:
- Decode and retire on one register: a design where the retire wins leaves that register out of the mask.
- Branch and producer in one cycle: a design that stamps the old index drops the register from the query for the new branch.
- Retire without the newest-definition flag: a design that clears on every retire loses registers from the mask.
- Equal index and query: a comparator that is strictly greater than drops registers written right after the mispredicted branch.

// File: rtl/srt_pkg.sv
package srt_pkg;

  // Width of a branch index: counter bits plus one color bit.
  function automatic int unsigned idx_width(input int unsigned max_br);
    return $clog2(max_br) + 1;
  endfunction

  // Width of a logical register designator.
  function automatic int unsigned reg_width(input int unsigned nregs);
    return (nregs > 1) ? $clog2(nregs) : 1;
  endfunction

endpackage

// File: rtl/srt_circ_ge.sv
module srt_circ_ge #(
  parameter int unsigned IDX_W = 7
) (
  input  logic [IDX_W-1:0] a_i,
  input  logic [IDX_W-1:0] b_i,
  output logic             ge_o
);
  localparam int unsigned VW = IDX_W - 1;

  logic same_col;
  logic val_gt;
  logic val_lt;
  logic a_gt_b;
  logic a_eq_b;

  always_comb begin
    same_col = (a_i[VW] == b_i[VW]);
    val_gt   = (a_i[VW-1:0] > b_i[VW-1:0]);
    val_lt   = (a_i[VW-1:0] < b_i[VW-1:0]);
    a_gt_b   = same_col ? val_gt : val_lt;
    a_eq_b   = (a_i == b_i);
    ge_o     = a_gt_b | a_eq_b;
  end
endmodule

// File: rtl/srt_branch_ctr.sv
module srt_branch_ctr #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_dec_i,
  output logic [IDX_W-1:0] cnt_o,
  output logic [IDX_W-1:0] nxt_o
);
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] cnt_d;
  logic             cnt_en;

  // The top bit carries out of the value field, so a plain increment
  // wraps the value to zero and flips the color together.
  always_comb begin
    nxt_o  = cnt_q + IDX_W'(1);
    cnt_en = br_dec_i;
    cnt_d  = nxt_o;
    cnt_o  = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/srt_reg_entry.sv
module srt_reg_entry #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [IDX_W-1:0] cmp_idx_i,
  output logic             hit_o
);
  logic             spec_q;
  logic             spec_d;
  logic             spec_en;
  logic [IDX_W-1:0] idx_q;
  logic             ge;

  // A decode outranks a retire on the same register.
  always_comb begin
    spec_en = set_i | clr_i;
    spec_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_q <= 1'b0;
    end else if (spec_en) begin
      spec_q <= spec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (set_i) begin
      idx_q <= wr_idx_i;
    end
  end

  srt_circ_ge #(.IDX_W(IDX_W)) u_ge (
    .a_i  (idx_q),
    .b_i  (cmp_idx_i),
    .ge_o (ge)
  );

  assign hit_o = spec_q & ge;
endmodule

// File: rtl/spec_reg_tracker.sv
module spec_reg_tracker #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned MAX_BR   = 64,
  parameter int unsigned IDX_W    = srt_pkg::idx_width(MAX_BR),
  parameter int unsigned RW       = srt_pkg::reg_width(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                br_dec_i,
  output logic [IDX_W-1:0]    br_idx_o,
  input  logic                prod_dec_i,
  input  logic [RW-1:0]       prod_dst_i,
  input  logic                ret_i,
  input  logic [RW-1:0]       ret_dst_i,
  input  logic                ret_latest_i,
  input  logic                misp_i,
  input  logic [IDX_W-1:0]    misp_idx_i,
  output logic [NUM_REGS-1:0] spec_mask_o
);
  logic [IDX_W-1:0]    cnt_cur;
  logic [IDX_W-1:0]    cnt_nxt;
  logic [IDX_W-1:0]    stamp_idx;
  logic [NUM_REGS-1:0] hit_vec;

  srt_branch_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_dec_i (br_dec_i),
    .cnt_o    (cnt_cur),
    .nxt_o    (cnt_nxt)
  );

  // A producer decoded alongside a branch belongs to that branch.
  always_comb begin
    stamp_idx = br_dec_i ? cnt_nxt : cnt_cur;
    br_idx_o  = cnt_nxt;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic set_r;
    logic clr_r;

    always_comb begin
      set_r = prod_dec_i && (prod_dst_i == RW'(r));
      clr_r = ret_i && ret_latest_i && (ret_dst_i == RW'(r));
    end

    srt_reg_entry #(.IDX_W(IDX_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_r),
      .clr_i     (clr_r),
      .wr_idx_i  (stamp_idx),
      .cmp_idx_i (misp_idx_i),
      .hit_o     (hit_vec[r])
    );
  end

  assign spec_mask_o = misp_i ? hit_vec : '0;
endmodule

// File: rtl/spec_reg_tracker_chk.sv
module spec_reg_tracker_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned IDX_W    = 7,
  parameter int unsigned RW       = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                br_dec_i,
  input logic [IDX_W-1:0]    br_idx_o,
  input logic                prod_dec_i,
  input logic [RW-1:0]       prod_dst_i,
  input logic                ret_i,
  input logic [RW-1:0]       ret_dst_i,
  input logic                ret_latest_i,
  input logic                misp_i,
  input logic [IDX_W-1:0]    misp_idx_i,
  input logic [NUM_REGS-1:0] spec_mask_o
);
  logic [IDX_W-1:0] exp_stamp;
  assign exp_stamp = br_dec_i ? br_idx_o : (br_idx_o - IDX_W'(1));

  // R2
  br_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_dec_i |=> (br_idx_o == ($past(br_idx_o) + IDX_W'(1))));

  // R2
  br_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_dec_i |=> $stable(br_idx_o));

  // R9
  mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !misp_i |-> (spec_mask_o == '0));

  // R3
  prod_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_dec_i |=> (!(misp_i && misp_idx_i == $past(exp_stamp))
                    || spec_mask_o[$past(prod_dst_i)]));

  // R4
  ret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && ret_latest_i && !(prod_dec_i && prod_dst_i == ret_dst_i))
      |=> (!misp_i || !spec_mask_o[$past(ret_dst_i)]));
endmodule

bind spec_reg_tracker spec_reg_tracker_chk #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W),
  .RW       (RW)
) u_chk (.*);

// File: tb/spec_reg_tracker_tb.sv
`timescale 1ns/1ps
module spec_reg_tracker_tb;
  localparam int unsigned NR = 8;
  localparam int unsigned NB = 4;
  localparam int unsigned IW = 3;
  localparam int unsigned RW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          br_dec_i;
  logic [IW-1:0] br_idx_o;
  logic          prod_dec_i;
  logic [RW-1:0] prod_dst_i;
  logic          ret_i;
  logic [RW-1:0] ret_dst_i;
  logic          ret_latest_i;
  logic          misp_i;
  logic [IW-1:0] misp_idx_i;
  logic [NR-1:0] spec_mask_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Model state
  bit          m_spec [NR];
  logic [IW-1:0] m_idx [NR];
  logic [IW-1:0] m_cnt;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  spec_reg_tracker #(.NUM_REGS(NR), .MAX_BR(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_dec_i(br_dec_i), .br_idx_o(br_idx_o),
    .prod_dec_i(prod_dec_i), .prod_dst_i(prod_dst_i), .ret_i(ret_i),
    .ret_dst_i(ret_dst_i), .ret_latest_i(ret_latest_i), .misp_i(misp_i),
    .misp_idx_i(misp_idx_i), .spec_mask_o(spec_mask_o)
  );

  // Circular >= computed arithmetically: (a-b) mod 2N below N.
  function automatic logic [NR-1:0] exp_mask(input logic [IW-1:0] q);
    logic [NR-1:0] m;
    for (int r = 0; r < NR; r++) begin
      logic [IW-1:0] d;
      d = m_idx[r] - q;
      m[r] = m_spec[r] && (int'(d) < NB);
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    br_dec_i = 0; prod_dec_i = 0; prod_dst_i = 0; ret_i = 0; ret_dst_i = 0;
    ret_latest_i = 0; misp_i = 0; misp_idx_i = 0;
  endtask

  // Inputs are set at a negedge; check, clock, update model, back to negedge.
  task automatic cycle(input string req);
    #1;
    chk({req, " R2 br_idx"}, 32'(br_idx_o), 32'(IW'(m_cnt + 1)));
    chk({req, " R8/R9 mask"}, 32'(spec_mask_o), misp_i ? 32'(exp_mask(misp_idx_i)) : 32'd0);
    @(posedge clk);
    if (br_dec_i) m_cnt = m_cnt + 1;
    if (ret_i && ret_latest_i) m_spec[ret_dst_i] = 0;
    if (prod_dec_i) begin
      m_spec[prod_dst_i] = 1;
      m_idx[prod_dst_i] = m_cnt;
    end
    @(negedge clk);
  endtask

  task automatic sweep_query(input string req);
    for (int q = 0; q < (1 << IW); q++) begin
      idle(); misp_i = 1; misp_idx_i = IW'(q);
      cycle(req);
    end
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    m_cnt = 0;
    for (int r = 0; r < NR; r++) begin m_spec[r] = 0; m_idx[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state, first branch index is 1, no register speculative
    #1 chk("R1 first index", 32'(br_idx_o), 32'd1);
    sweep_query("R1 reset");

    // R3: producer without branches stamps index 0
    idle(); prod_dec_i = 1; prod_dst_i = 3'd6; cycle("R3 stamp");
    idle(); misp_i = 1; misp_idx_i = 3'd0; #1;
    chk("R3 marked", 32'(spec_mask_o[6]), 32'd1);
    cycle("R3");

    // R6: branch and producer together
    idle(); br_dec_i = 1; prod_dec_i = 1; prod_dst_i = 3'd3; cycle("R6");
    idle(); misp_i = 1; misp_idx_i = 3'd1; #1;
    chk("R6 new index", 32'(spec_mask_o[3]), 32'd1);
    chk("R6 older reg", 32'(spec_mask_o[6]), 32'd0);
    cycle("R6");

    // R5: decode and clearing retire on the same register
    idle(); prod_dec_i = 1; prod_dst_i = 3'd2; ret_i = 1; ret_dst_i = 3'd2;
    ret_latest_i = 1; cycle("R5");
    idle(); misp_i = 1; misp_idx_i = 3'd1; #1;
    chk("R5 decode wins", 32'(spec_mask_o[2]), 32'd1);
    cycle("R5");

    // R4: retire without latest does nothing; with latest clears
    idle(); ret_i = 1; ret_dst_i = 3'd3; ret_latest_i = 0; cycle("R4");
    idle(); misp_i = 1; misp_idx_i = 3'd1; #1;
    chk("R4 not latest kept", 32'(spec_mask_o[3]), 32'd1);
    cycle("R4");
    idle(); ret_i = 1; ret_dst_i = 3'd3; ret_latest_i = 1; cycle("R4");
    idle(); misp_i = 1; misp_idx_i = 3'd1; #1;
    chk("R4 latest cleared", 32'(spec_mask_o[3]), 32'd0);
    cycle("R4");

    // R7: wrap of value flips color (counter now 1; go to 4 -> 3'b100)
    for (int k = 0; k < 3; k++) begin idle(); br_dec_i = 1; cycle("R7"); end
    #1 chk("R7 wrap color", 32'(br_idx_o), 32'b101);
    idle(); prod_dec_i = 1; prod_dst_i = 3'd7; cycle("R7");
    sweep_query("R8 after wrap");

    // R8: pseudo-random streams with periodic full query sweeps
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      idle();
      br_dec_i     = lfsr[0] & lfsr[5];
      prod_dec_i   = lfsr[1];
      prod_dst_i   = lfsr[4:2];
      ret_i        = lfsr[6];
      ret_dst_i    = lfsr[9:7];
      ret_latest_i = lfsr[10];
      misp_i       = lfsr[11];
      misp_idx_i   = lfsr[14:12];
      cycle("R8 stream");
      if (n % 200 == 199) sweep_query("R8 sweep");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule